// File: doc/BRIEF.md
# Serial Flash Page-Read Responder

This block is the device side of a serial flash read path. An SPI host lowers the chip select and sends one command byte, three address bytes and four filler bytes. The block then streams bytes from one page of a small on-chip array. The array keeps a paged layout. A static mode pin picks one of two page sizes: 264 bytes, or 256 bytes. The number of pages is a parameter, so the array can be kept small for simulation.

All SPI inputs are sampled by the local system clock through a short synchronizer, and this clock runs several times faster than the serial clock. The serial clock follows mode 0: the block samples input bits when the serial clock rises and changes its output when it falls. Bytes move most significant bit first. The output pin is a data bit paired with an output enable, so the pad driver is tri-stated whenever the enable is low. A separate load port, clocked by the system clock, writes bytes into the array before any reads.

Top module: `flash_page_reader`

## Requirements
- R1: Only the command byte 0xD2 starts a read. After any other command byte, so_oe stays low for the rest of that chip-select window, whatever bytes follow.
- R2: After 0xD2 the block takes three address bytes and then four filler bytes. so_oe stays low until the serial clock falls after the last bit of the fourth filler byte, and it is high from that falling edge on.
- R3: In 264-byte mode, address bits 20:9 give the page and bits 8:0 give the start byte. Bits 23:21 are ignored.
- R4: In 256-byte mode, address bits 19:8 give the page and bits 7:0 give the start byte. Bits 23:20 are ignored.
- R5: Each input bit is taken when the serial clock rises. Each output bit changes when it falls. Bytes travel most significant bit first, and the first byte sent is the addressed byte.
- R6: Once the last byte of the page has been sent (byte 263 in 264-byte mode, byte 255 in 256-byte mode), output continues at byte 0 of the same page with no gap.
- R7: When chip select goes high, the read ends and so_oe goes low within four system clocks. The next low window starts again from command capture.
- R8: A start byte of 264 or more in 264-byte mode is taken modulo 264. A page number of PAGES or more is taken modulo PAGES.
- R9: While rst_n is low, so_oe is low and the block waits for a command byte.
- R10: A read leaves the array contents unchanged, so repeating a read returns the same bytes.
- R11: When ld_en is high on a system clock edge, ld_data is written to byte ld_off of page ld_page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the SPI pins and runs the load port |
| rst_n | input | 1 | Asynchronous reset, active low |
| page_256 | input | 1 | Static page-size select: 1 selects 256 bytes, 0 selects 264 bytes |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for the so pad driver |
| ld_en | input | 1 | Write strobe for the load port |
| ld_page | input | PG_W | Page index for the load port |
| ld_off | input | 9 | Byte offset within the page for the load port |
| ld_data | input | 8 | Byte written by the load port |

## Verification
The whole array is filled with a pattern that depends on both the page and the offset. Bytes 0 and 256 of the same page hold different values, so a wrong page, a wrong offset or a wrong wrap point shows up as a value mismatch. Reads are run in both page-size modes with the ignored top address bits set to ones, which separates the two address layouts. Start offsets just below the end of a page show whether the wrap point depends on the mode. An out-of-range offset and an out-of-range page show the modulo folding. A wrong command byte, a chip-select release in the middle of a byte, and the enable level just before and just after the last filler edge check when the output driver turns on and off.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
   localparam int unsigned PG_BYTES_STD = 264;
   localparam int unsigned PG_BYTES_BIN = 256;
   localparam int unsigned OFF_W        = 9;
   localparam int unsigned PAGE_FLD_W   = 12;
   localparam int unsigned ADDR_BYTES   = 3;

   typedef enum logic [2:0] {
      ST_CMD   = 3'd0,
      ST_ADDR  = 3'd1,
      ST_PAD   = 3'd2,
      ST_DATA  = 3'd3,
      ST_SKIP  = 3'd4
   } fpr_state_e;
endpackage

// File: rtl/fpr_sync.sv
module fpr_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic mosi,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_hi,
   output logic mosi_s
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("fpr_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sck_sr, cs_sr, mosi_sr;
   logic                   sck_prev;

   generate
      if (SYNC_STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_sr  <= '0;
               cs_sr   <= '1;
               mosi_sr <= '0;
            end else begin
               sck_sr  <= {sck_sr[0], sck};
               cs_sr   <= {cs_sr[0], cs_n};
               mosi_sr <= {mosi_sr[0], mosi};
            end
         end
      end else begin : g_deep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_sr  <= '0;
               cs_sr   <= '1;
               mosi_sr <= '0;
            end else begin
               sck_sr  <= {sck_sr[SYNC_STAGES-2:0], sck};
               cs_sr   <= {cs_sr[SYNC_STAGES-2:0], cs_n};
               mosi_sr <= {mosi_sr[SYNC_STAGES-2:0], mosi};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= sck_sr[SYNC_STAGES-1];
   end

   assign sck_rise = sck_sr[SYNC_STAGES-1] & ~sck_prev;
   assign sck_fall = ~sck_sr[SYNC_STAGES-1] & sck_prev;
   assign cs_hi    = cs_sr[SYNC_STAGES-1];
   assign mosi_s   = mosi_sr[SYNC_STAGES-1];

   // R5: a single serial clock transition yields exactly one edge pulse
   p_one_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sck_rise |=> !sck_rise);
endmodule

// File: rtl/fpr_store.sv
module fpr_store import fpr_pkg::*; #(
   parameter int unsigned PAGES = 4,
   localparam int unsigned PG_W  = (PAGES > 1) ? $clog2(PAGES) : 1,
   localparam int unsigned DEPTH = PAGES * PG_BYTES_STD,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PG_W-1:0]  wr_page,
   input  logic [OFF_W-1:0] wr_off,
   input  logic [7:0]       wr_data,
   input  logic [PG_W-1:0]  rd_page,
   input  logic [OFF_W-1:0] rd_off,
   output logic [7:0]       rd_data
);
   logic [7:0]       mem [DEPTH];
   logic [IDX_W-1:0] widx, ridx;

   assign widx = IDX_W'(wr_page) * IDX_W'(PG_BYTES_STD) + IDX_W'(wr_off);
   assign ridx = IDX_W'(rd_page) * IDX_W'(PG_BYTES_STD) + IDX_W'(rd_off);

   always_ff @(posedge clk) begin
      if (wr_en) mem[widx] <= wr_data;
   end

   assign rd_data = mem[ridx];

   // R11: load writes must land inside the array
   p_load_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_off) < PG_BYTES_STD) && (int'(wr_page) < PAGES));
endmodule

// File: rtl/fpr_seq.sv
module fpr_seq import fpr_pkg::*; #(
   parameter int unsigned PAGES       = 4,
   parameter int unsigned DUMMY_BYTES = 4,
   parameter logic [7:0]  READ_CMD    = 8'hD2,
   localparam int unsigned PG_W  = (PAGES > 1) ? $clog2(PAGES) : 1,
   localparam int unsigned CNT_W = $clog2(DUMMY_BYTES + ADDR_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             page_256,
   input  logic             sck_rise,
   input  logic             sck_fall,
   input  logic             cs_hi,
   input  logic             mosi_s,
   input  logic [7:0]       rd_data,
   output logic [PG_W-1:0]  rd_page,
   output logic [OFF_W-1:0] rd_off,
   output logic             so,
   output logic             so_oe
);
   generate
      if (DUMMY_BYTES < 1) begin : g_bad_dummy
         $error("fpr_seq: DUMMY_BYTES must be at least 1");
      end
   endgenerate

   fpr_state_e       st_q;
   logic [2:0]       rbit_q, fbit_q;
   logic [7:0]       rx_q, osh_q;
   logic [12:0]      addr_q;
   logic [CNT_W-1:0] bcnt_q;
   logic [PG_W-1:0]  page_q;
   logic [OFF_W-1:0] off_q;
   logic             so_q, oe_q;

   logic [7:0]            rx_byte;
   logic                  byte_done;
   logic [20:0]           full_addr;
   logic [PAGE_FLD_W-1:0] page_raw;
   logic [PG_W-1:0]       page_fold;
   logic [OFF_W-1:0]      off_fold, off_last, off_next;

   always_comb begin
      rx_byte   = {rx_q[6:0], mosi_s};
      byte_done = sck_rise && (rbit_q == 3'd7);
      full_addr = {addr_q, rx_byte};
      page_raw  = page_256 ? full_addr[19:8] : full_addr[20:9];
      if (page_256)
         off_fold = {1'b0, full_addr[7:0]};
      else if (full_addr[8:0] >= OFF_W'(PG_BYTES_STD))
         off_fold = full_addr[8:0] - OFF_W'(PG_BYTES_STD);
      else
         off_fold = full_addr[8:0];
      off_last = page_256 ? OFF_W'(PG_BYTES_BIN - 1) : OFF_W'(PG_BYTES_STD - 1);
      off_next = (off_q == off_last) ? '0 : off_q + 1'b1;
   end

   generate
      if ((PAGES & (PAGES - 1)) == 0) begin : g_pow2_fold
         assign page_fold = PG_W'(page_raw & PAGE_FLD_W'(PAGES - 1));
      end else begin : g_mod_fold
         assign page_fold = PG_W'(page_raw % PAGE_FLD_W'(PAGES));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_CMD;
         rbit_q <= '0;
         fbit_q <= '0;
         rx_q   <= '0;
         osh_q  <= '0;
         addr_q <= '0;
         bcnt_q <= '0;
         page_q <= '0;
         off_q  <= '0;
         so_q   <= 1'b0;
         oe_q   <= 1'b0;
      end else if (cs_hi) begin
         st_q   <= ST_CMD;
         rbit_q <= '0;
         fbit_q <= '0;
         bcnt_q <= '0;
         oe_q   <= 1'b0;
      end else begin
         if (sck_rise) begin
            rx_q   <= rx_byte;
            rbit_q <= rbit_q + 1'b1;
         end
         unique case (st_q)
            ST_CMD: if (byte_done) begin
               st_q   <= (rx_byte == READ_CMD) ? ST_ADDR : ST_SKIP;
               bcnt_q <= '0;
            end
            ST_ADDR: if (byte_done) begin
               if (bcnt_q == '0) addr_q <= {8'h00, rx_byte[4:0]};
               else              addr_q <= {addr_q[4:0], rx_byte};
               if (bcnt_q == CNT_W'(ADDR_BYTES - 1)) begin
                  st_q   <= ST_PAD;
                  bcnt_q <= '0;
                  page_q <= page_fold;
                  off_q  <= off_fold;
               end else begin
                  bcnt_q <= bcnt_q + 1'b1;
               end
            end
            ST_PAD: if (byte_done) begin
               if (bcnt_q == CNT_W'(DUMMY_BYTES - 1)) begin
                  st_q   <= ST_DATA;
                  fbit_q <= '0;
               end else begin
                  bcnt_q <= bcnt_q + 1'b1;
               end
            end
            ST_DATA: if (sck_fall) begin
               oe_q   <= 1'b1;
               fbit_q <= fbit_q + 1'b1;
               if (fbit_q == 3'd0) begin
                  so_q  <= rd_data[7];
                  osh_q <= {rd_data[6:0], 1'b0};
                  off_q <= off_next;
               end else begin
                  so_q  <= osh_q[7];
                  osh_q <= {osh_q[6:0], 1'b0};
               end
            end
            default: ;
         endcase
      end
   end

   assign rd_page = page_q;
   assign rd_off  = off_q;
   assign so      = so_q;
   assign so_oe   = oe_q;

   // R2: the driver is only enabled while streaming data
   p_oe_in_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      oe_q |-> st_q == ST_DATA);
   // R1: a rejected command never enables the driver
   p_skip_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SKIP) |=> !oe_q);
   // R7: chip select high releases the driver
   p_cs_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_hi |=> !oe_q && st_q == ST_CMD);
   // R6: offset wraps to zero after the last byte of the page
   p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DATA && !cs_hi && sck_fall && fbit_q == 3'd0 && off_q == off_last)
      |=> off_q == '0);
   // R8: a selected page is always inside the array
   p_page_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      int'(page_q) < PAGES);
   // R8: the streaming offset stays within the active page size
   p_off_in_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DATA) |-> off_q <= off_last);
endmodule

// File: rtl/flash_page_reader.sv
module flash_page_reader import fpr_pkg::*; #(
   parameter int unsigned PAGES       = 4,
   parameter int unsigned DUMMY_BYTES = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [7:0]  READ_CMD    = 8'hD2,
   localparam int unsigned PG_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             page_256,
   input  logic             sck,
   input  logic             cs_n,
   input  logic             mosi,
   output logic             so,
   output logic             so_oe,
   input  logic             ld_en,
   input  logic [PG_W-1:0]  ld_page,
   input  logic [OFF_W-1:0] ld_off,
   input  logic [7:0]       ld_data
);
   generate
      if (PAGES < 2 || PAGES > 4096) begin : g_bad_pages
         $error("flash_page_reader: PAGES must be within 2..4096");
      end
   endgenerate

   logic             sck_rise, sck_fall, cs_hi, mosi_s;
   logic [PG_W-1:0]  rd_page;
   logic [OFF_W-1:0] rd_off;
   logic [7:0]       rd_data;

   fpr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck      (sck),
      .cs_n     (cs_n),
      .mosi     (mosi),
      .sck_rise (sck_rise),
      .sck_fall (sck_fall),
      .cs_hi    (cs_hi),
      .mosi_s   (mosi_s)
   );

   fpr_store #(.PAGES(PAGES)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ld_en),
      .wr_page (ld_page),
      .wr_off  (ld_off),
      .wr_data (ld_data),
      .rd_page (rd_page),
      .rd_off  (rd_off),
      .rd_data (rd_data)
   );

   fpr_seq #(
      .PAGES       (PAGES),
      .DUMMY_BYTES (DUMMY_BYTES),
      .READ_CMD    (READ_CMD)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .page_256  (page_256),
      .sck_rise  (sck_rise),
      .sck_fall  (sck_fall),
      .cs_hi     (cs_hi),
      .mosi_s    (mosi_s),
      .rd_data   (rd_data),
      .rd_page   (rd_page),
      .rd_off    (rd_off),
      .so        (so),
      .so_oe     (so_oe)
   );

   // R9: output driver is off during reset release
   p_reset_quiet_r9: assert property (@(posedge clk)
      !rst_n |-> !so_oe);
endmodule

// File: tb/flash_page_reader_tb.sv
module flash_page_reader_tb;
   localparam int PAGES = 4;
   localparam int PG_W  = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            page_256 = 1'b0;
   logic            sck = 1'b0;
   logic            cs_n = 1'b1;
   logic            mosi = 1'b0;
   logic            so, so_oe;
   logic            ld_en = 1'b0;
   logic [PG_W-1:0] ld_page = '0;
   logic [8:0]      ld_off = '0;
   logic [7:0]      ld_data = '0;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   flash_page_reader #(.PAGES(PAGES)) u_dut (
      .clk(clk), .rst_n(rst_n), .page_256(page_256), .sck(sck), .cs_n(cs_n),
      .mosi(mosi), .so(so), .so_oe(so_oe), .ld_en(ld_en), .ld_page(ld_page),
      .ld_off(ld_off), .ld_data(ld_data)
   );

   function automatic logic [7:0] pat(int p, int o);
      return 8'(o + p * 71 + (o >> 8) * 13);
   endfunction

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(bit ok, string req, int act, int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic spi_byte(logic [7:0] b, bit hold_high);
      for (int i = 7; i >= 0; i--) begin
         mosi = b[i];
         tick(4);
         sck = 1'b1;
         tick(4);
         if (i != 0 || !hold_high) sck = 1'b0;
      end
   endtask

   task automatic read_byte(output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         tick(4);
         b[i] = so;
         sck = 1'b1;
         tick(4);
         sck = 1'b0;
      end
   endtask

   // header with filler-phase checks on the driver enable (R2)
   task automatic send_header(logic [7:0] cmd, logic [23:0] a, bit expect_on);
      cs_n = 1'b0;
      tick(4);
      spi_byte(cmd, 1'b0);
      spi_byte(a[23:16], 1'b0);
      spi_byte(a[15:8], 1'b0);
      spi_byte(a[7:0], 1'b0);
      for (int d = 0; d < 3; d++) spi_byte(8'hA5, 1'b0);
      check(so_oe == 1'b0, "R2 off during filler", so_oe, 0);
      spi_byte(8'h5A, 1'b1);
      check(so_oe == 1'b0, "R2 off before last falling edge", so_oe, 0);
      sck = 1'b0;
      tick(4);
      check(so_oe == expect_on, "R2 R1 enable after filler", so_oe, expect_on);
      tick(-0);
   endtask

   task automatic close_cs();
      cs_n = 1'b1;
      tick(4);
      check(so_oe == 1'b0, "R7 released on cs high", so_oe, 0);
   endtask

   task automatic do_read(bit m256, logic [23:0] a, int page, int off, int n, string req);
      logic [7:0] got;
      int o = off;
      int last = m256 ? 255 : 263;
      page_256 = m256;
      send_header(8'hD2, a, 1'b1);
      for (int k = 0; k < n; k++) begin
         read_byte(got);
         check(got == pat(page, o), req, got, pat(page, o));
         o = (o == last) ? 0 : o + 1;
      end
      close_cs();
   endtask

   task automatic t_reset();
      check(so_oe == 1'b0, "R9 reset enable", so_oe, 0);
      rst_n = 1'b1;
      tick(3);
      check(so_oe == 1'b0, "R9 idle after reset", so_oe, 0);
   endtask

   task automatic t_load();
      for (int p = 0; p < PAGES; p++)
         for (int o = 0; o < 264; o++) begin
            ld_en = 1'b1; ld_page = PG_W'(p); ld_off = 9'(o); ld_data = pat(p, o);
            tick(1);
         end
      ld_en = 1'b0;
      tick(2);
   endtask

   task automatic t_std_mode();
      // R3: page 2, byte 5, top three bits set and ignored
      do_read(1'b0, {3'b111, 12'd2, 9'd5}, 2, 5, 4, "R3 R5 R11 264-byte read");
   endtask

   task automatic t_bin_mode();
      // R4: page 1, byte 10, top four bits set and ignored
      do_read(1'b1, {4'hF, 12'd1, 8'd10}, 1, 10, 4, "R4 R5 256-byte read");
   endtask

   task automatic t_wrap();
      do_read(1'b0, {3'b000, 12'd3, 9'd262}, 3, 262, 4, "R6 wrap at 263");
      do_read(1'b1, {4'h0, 12'd3, 8'd254}, 3, 254, 4, "R6 wrap at 255");
   endtask

   task automatic t_bad_cmd();
      logic [7:0] got;
      page_256 = 1'b0;
      send_header(8'h0B, {3'b000, 12'd1, 9'd0}, 1'b0);
      read_byte(got);
      read_byte(got);
      check(so_oe == 1'b0, "R1 silent after foreign command", so_oe, 0);
      close_cs();
      do_read(1'b0, {3'b000, 12'd1, 9'd0}, 1, 0, 2, "R1 R7 valid read after foreign command");
   endtask

   task automatic t_fold();
      // R8: byte 300 -> 36, page 6 -> 2
      do_read(1'b0, {3'b000, 12'd6, 9'd300}, 2, 36, 2, "R8 offset and page folding");
   endtask

   task automatic t_repeat();
      do_read(1'b0, {3'b000, 12'd0, 9'd100}, 0, 100, 3, "R10 first pass");
      do_read(1'b0, {3'b000, 12'd0, 9'd100}, 0, 100, 3, "R10 repeat pass");
   endtask

   task automatic t_abort();
      logic [7:0] got;
      page_256 = 1'b0;
      send_header(8'hD2, {3'b000, 12'd2, 9'd40}, 1'b1);
      sck = 1'b1; tick(4); sck = 1'b0; tick(4);
      check(so_oe == 1'b1, "R7 driving mid byte", so_oe, 1);
      cs_n = 1'b1;
      tick(4);
      check(so_oe == 1'b0, "R7 abort mid byte", so_oe, 0);
      do_read(1'b0, {3'b000, 12'd2, 9'd40}, 2, 40, 1, "R7 fresh read after abort");
      got = 8'h00;
   endtask

   initial begin
      tick(5);
      t_reset();
      t_load();
      t_std_mode();
      t_bin_mode();
      t_wrap();
      t_bad_cmd();
      t_fold();
      t_repeat();
      t_abort();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule